// File: doc/BRIEF.md
# Router Port In-Network Processing Controller

This block sits on one input port of a mesh network-on-chip router, between the link and the crossbar. Normally every flit is written into a small input FIFO and offered to the crossbar from the FIFO head. A control flit addressed to this router can instead divert the next N payload flits through a small compute core inside the port. The core's results go to the crossbar in place of the raw payload. After the last result has left, the port returns to plain forwarding.

A three-state controller owns the two steering points. The first point chooses whether an incoming flit goes to the FIFO, to the core, or nowhere. The second point chooses whether the crossbar sees the FIFO head or the core output. A run counter tracks how many payload flits the core has taken. The example core is a threshold comparator with one register stage. Both flit streams use valid/ready handshakes. A transfer happens only in a cycle where both valid and ready are high.

Top module: `innet_proc_port`

## Requirements
- R1: After reset the controller is in forwarding mode, `out_valid` is 0 and `in_ready` is 1.
- R2: In forwarding mode, flits of every kind leave on the output in arrival order with type and data unchanged. The type encoding is 00 header, 01 control, 10 payload, 11 tail.
- R3: A control flit carries x in data[31:28], y in data[27:24] and a run length in data[15:0]. A control flit whose x/y differ from the parameters `MY_X`/`MY_Y` is forwarded unchanged, and the port stays in forwarding mode.
- R4: A control flit whose x/y match this router is removed from the FIFO and never appears on the output. A non-zero run length moves the controller to diverting mode.
- R5: In diverting mode, each accepted flit goes to the core. Its result is offered on the output in the cycle after acceptance, with type payload. The data is 1 when the input, read as a signed number, is at least `THRESHOLD` (110), and 0 otherwise. All higher data bits are zero.
- R6: Once the core has accepted as many flits as the run length, the controller enters draining mode. In draining mode, `in_ready` stays 0 until the last result has been transferred.
- R7: The transfer of the last result returns the controller to forwarding mode. The flits that follow (tail and beyond) pass through the FIFO unchanged.
- R8: A matching control flit with run length 0 is consumed, and the port stays in forwarding mode. The next flit is forwarded unchanged.
- R9: While a control flit sits in the FIFO, `in_ready` is 0. No flit is accepted behind it until it leaves.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output type and data hold stable in the following cycle.
- R11: The FIFO holds `DEPTH` flits. When it is full in forwarding mode, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit valid |
| in_ready | output | 1 | Port can accept the incoming flit |
| in_type | input | 2 | Incoming flit type |
| in_data | input | DATA_W | Incoming flit data |
| out_valid | output | 1 | Flit offered to the crossbar |
| out_ready | input | 1 | Crossbar accepts the flit |
| out_type | output | 2 | Outgoing flit type |
| out_data | output | DATA_W | Outgoing flit data |

## Verification
Several properties are checked by the assertions on every cycle:
- input is blocked while draining;
- a locally addressed control flit never reaches the output;
- the output holds steady under backpressure;
- core results are single-bit payloads that appear one cycle after each accepted flit;
- the run counter stays below its target;
- the controller returns to forwarding on the final result.

Some behaviour can only be shown by the directed scenarios. These cover the exact result values on both sides of the threshold, including a negative input. They also cover the order and integrity of forwarded traffic before and after a diverted run, foreign and zero-length control flits, the stall behind a buffered control flit, and the FIFO-full limit.

// File: rtl/inp_pkg.sv
package inp_pkg;
   typedef enum logic [1:0] {
      FT_HEAD  = 2'b00,
      FT_INSTR = 2'b01,
      FT_PAY   = 2'b10,
      FT_TAIL  = 2'b11
   } flit_kind_e;

   typedef enum logic [1:0] {
      ST_FWD   = 2'b00,
      ST_DIVERT = 2'b01,
      ST_DRAIN = 2'b10
   } port_mode_e;
endpackage

// File: rtl/inp_fifo.sv
module inp_fifo #(
   parameter int W     = 34,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;

   assign empty = (wp == rp);
   assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign rdata = mem[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push && !full) wp <= wp + 1'b1;
         if (pop && !empty) rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) mem[wp[AW-1:0]] <= wdata;
   end
endmodule

// File: rtl/inp_thresh_core.sv
module inp_thresh_core #(
   parameter int DATA_W      = 32,
   parameter int THRESHOLD   = 110,
   parameter bit CORE_SIGNED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_fire,
   input  logic [DATA_W-1:0] in_data,
   input  logic              res_ready,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic              can_take
);
   localparam logic [DATA_W-1:0] THR = DATA_W'(THRESHOLD);

   logic at_or_above;

   generate
      if (CORE_SIGNED) begin : g_signed
         assign at_or_above = $signed(in_data) >= $signed(THR);
      end else begin : g_unsigned
         assign at_or_above = in_data >= THR;
      end
   endgenerate

   assign can_take = !res_valid || res_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
      end else if (in_fire) begin
         res_valid <= 1'b1;
         res_data  <= {{(DATA_W-1){1'b0}}, at_or_above};
      end else if (res_ready) begin
         res_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/inp_ctrl.sv
module inp_ctrl
   import inp_pkg::*;
#(
   parameter int COUNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_consume,
   input  logic [COUNT_W-1:0] instr_count,
   input  logic               core_accept,
   input  logic               core_drain,
   input  logic               instr_in,
   input  logic               instr_out,
   output port_mode_e         mode,
   output logic [COUNT_W-1:0] run_cnt,
   output logic [COUNT_W-1:0] run_target,
   output logic               instr_pending
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode       <= ST_FWD;
         run_cnt    <= '0;
         run_target <= '0;
      end else begin
         unique case (mode)
            ST_FWD: begin
               if (instr_consume && instr_count != '0) begin
                  mode       <= ST_DIVERT;
                  run_target <= instr_count;
                  run_cnt    <= '0;
               end
            end
            ST_DIVERT: begin
               if (core_accept) begin
                  run_cnt <= run_cnt + 1'b1;
                  if (run_cnt + 1'b1 == run_target) mode <= ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (core_drain) mode <= ST_FWD;
            end
            default: mode <= ST_FWD;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         instr_pending <= 1'b0;
      else if (instr_in)  instr_pending <= 1'b1;
      else if (instr_out) instr_pending <= 1'b0;
   end
endmodule

// File: rtl/innet_proc_port.sv
module innet_proc_port
   import inp_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int DEPTH       = 4,
   parameter int COORD_W     = 4,
   parameter int COUNT_W     = 16,
   parameter int MY_X        = 1,
   parameter int MY_Y        = 1,
   parameter int THRESHOLD   = 110,
   parameter bit CORE_SIGNED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_type,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [1:0]        out_type,
   output logic [DATA_W-1:0] out_data
);
   localparam int FW    = DATA_W + 2;
   localparam int X_HI  = DATA_W - 1;
   localparam int Y_HI  = DATA_W - 1 - COORD_W;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two and at least 2");
      end
      if (2 * COORD_W + COUNT_W > DATA_W) begin : g_bad_fields
         $error("coordinate and count fields exceed DATA_W");
      end
   endgenerate

   port_mode_e         mode;
   logic [COUNT_W-1:0] run_cnt, run_target;
   logic               instr_pending;

   logic [FW-1:0]      head;
   logic               f_empty, f_full, f_push, f_pop;
   logic [1:0]         head_type;
   logic [DATA_W-1:0]  head_data;
   logic               head_is_instr, head_match;

   logic               core_valid, core_take, core_in_fire, core_rdy;
   logic [DATA_W-1:0]  core_data;

   logic               fwd;

   assign fwd           = (mode == ST_FWD);
   assign head_type     = head[FW-1 -: 2];
   assign head_data     = head[DATA_W-1:0];
   assign head_is_instr = !f_empty && (head_type == FT_INSTR);
   assign head_match    = head_is_instr
                          && (head_data[X_HI -: COORD_W] == COORD_W'(MY_X))
                          && (head_data[Y_HI -: COORD_W] == COORD_W'(MY_Y));

   // first steering point: FIFO, core or closed
   always_comb begin
      unique case (mode)
         ST_FWD:    in_ready = !f_full && !instr_pending;
         ST_DIVERT: in_ready = core_take;
         default:   in_ready = 1'b0;
      endcase
   end

   assign f_push       = fwd && in_valid && in_ready;
   assign core_in_fire = (mode == ST_DIVERT) && in_valid && in_ready;
   assign f_pop        = fwd && !f_empty && (head_match || out_ready);
   assign core_rdy     = !fwd && out_ready;

   // second steering point: FIFO head or core result
   assign out_valid = fwd ? (!f_empty && !head_match) : core_valid;
   assign out_type  = fwd ? head_type : FT_PAY;
   assign out_data  = fwd ? head_data : core_data;

   inp_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (f_push),
      .wdata ({in_type, in_data}),
      .pop   (f_pop),
      .rdata (head),
      .empty (f_empty),
      .full  (f_full)
   );

   inp_thresh_core #(.DATA_W(DATA_W), .THRESHOLD(THRESHOLD), .CORE_SIGNED(CORE_SIGNED)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_fire   (core_in_fire),
      .in_data   (in_data),
      .res_ready (core_rdy),
      .res_valid (core_valid),
      .res_data  (core_data),
      .can_take  (core_take)
   );

   inp_ctrl #(.COUNT_W(COUNT_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .instr_consume (fwd && head_match),
      .instr_count   (head_data[COUNT_W-1:0]),
      .core_accept   (core_in_fire),
      .core_drain    (core_valid && core_rdy),
      .instr_in      (f_push && in_type == FT_INSTR),
      .instr_out     (f_pop && head_is_instr),
      .mode          (mode),
      .run_cnt       (run_cnt),
      .run_target    (run_target),
      .instr_pending (instr_pending)
   );
endmodule

// File: rtl/inp_checker.sv
module inp_checker #(
   parameter int DATA_W  = 32,
   parameter int COORD_W = 4,
   parameter int COUNT_W = 16,
   parameter int MY_X    = 1,
   parameter int MY_Y    = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic               out_valid,
   input logic               out_ready,
   input logic [1:0]         out_type,
   input logic [DATA_W-1:0]  out_data,
   input logic [1:0]         mode,
   input logic [COUNT_W-1:0] run_cnt,
   input logic [COUNT_W-1:0] run_target
);
   localparam logic [1:0] M_FWD = 2'b00, M_DIV = 2'b01, M_DRN = 2'b10;

   p_drain_blocks_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_DRN) |-> !in_ready);

   p_count_below_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_DIV) |-> (run_cnt < run_target));

   p_local_instr_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_type == 2'b01) |->
      !((out_data[DATA_W-1 -: COORD_W] == COORD_W'(MY_X)) &&
        (out_data[DATA_W-1-COORD_W -: COORD_W] == COORD_W'(MY_Y))));

   p_hold_under_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_type)));

   p_result_binary_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != M_FWD && out_valid) |-> (out_data[DATA_W-1:1] == '0 && out_type == 2'b10));

   p_core_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_DIV && in_valid && in_ready) |=> (out_valid && mode != M_FWD));

   p_resume_forward_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_DRN && out_valid && out_ready) |=> (mode == M_FWD));
endmodule

bind innet_proc_port inp_checker #(
   .DATA_W(DATA_W), .COORD_W(COORD_W), .COUNT_W(COUNT_W), .MY_X(MY_X), .MY_Y(MY_Y)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_type   (out_type),
   .out_data   (out_data),
   .mode       (mode),
   .run_cnt    (run_cnt),
   .run_target (run_target)
);

// File: tb/tb_innet_proc_port.sv
module tb_innet_proc_port;
   localparam int DEPTH = 4;
   localparam logic [1:0] HD = 2'b00, IN = 2'b01, PY = 2'b10, TL = 2'b11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_ready;
   logic [1:0]  in_type = '0;
   logic [31:0] in_data = '0;
   logic        out_valid, out_ready = 1'b1;
   logic [1:0]  out_type;
   logic [31:0] out_data;

   int n_chk = 0, n_bad = 0;
   logic [33:0] q_f[$];
   string       q_r[$];

   always #2.5 clk = ~clk;

   innet_proc_port dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type), .out_data(out_data)
   );

   function automatic logic [31:0] ctl(input int x, input int y, input int n);
      return {4'(x), 4'(y), 8'h00, 16'(n)};
   endfunction

   task automatic chk(input string r, input logic [33:0] act, input logic [33:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic expect_out(input logic [1:0] t, input logic [31:0] d, input string r);
      q_f.push_back({t, d});
      q_r.push_back(r);
   endtask

   // one cycle, entered just after a falling edge with inputs already set
   task automatic cyc(output bit acc);
      #1;
      acc = in_valid && in_ready;
      if (out_valid && out_ready) begin
         if (q_f.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R4 actual=%h expected=none", {out_type, out_data});
         end else begin
            chk(q_r.pop_front(), {out_type, out_data}, q_f.pop_front());
         end
      end
      @(negedge clk);
   endtask

   task automatic send(input logic [1:0] t, input logic [31:0] d);
      bit acc;
      in_type = t; in_data = d; in_valid = 1'b1;
      do cyc(acc); while (!acc);
      in_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      bit acc;
      repeat (n) cyc(acc);
   endtask

   task automatic all_out(input string r);
      chk(r, 34'(q_f.size()), 34'd0);
      q_f.delete(); q_r.delete();
   endtask

   task automatic t_reset;
      #1;
      chk("R1", {33'd0, in_ready}, 34'd1);
      chk("R1", {33'd0, out_valid}, 34'd0);
      @(negedge clk);
   endtask

   task automatic t_pass;
      expect_out(HD, 32'h0000_00A5, "R2");
      expect_out(PY, 32'h1234_5678, "R2");
      expect_out(PY, 32'h0000_0005, "R2");
      expect_out(TL, 32'hDEAD_BEEF, "R2");
      send(HD, 32'h0000_00A5);
      send(PY, 32'h1234_5678);
      send(PY, 32'h0000_0005);
      send(TL, 32'hDEAD_BEEF);
      idle(4);
      all_out("R2");
   endtask

   task automatic t_foreign;
      expect_out(IN, ctl(2, 3, 3), "R3");
      expect_out(PY, 32'd200, "R3");
      expect_out(PY, 32'd5, "R3");
      send(IN, ctl(2, 3, 3));
      send(PY, 32'd200);
      send(PY, 32'd5);
      idle(4);
      all_out("R3");
   endtask

   task automatic t_process;
      logic [31:0] held;
      expect_out(HD, 32'h0000_0011, "R2");
      expect_out(PY, 32'd0, "R5");
      expect_out(PY, 32'd1, "R5");
      expect_out(PY, 32'd1, "R5");
      expect_out(PY, 32'd0, "R5");
      send(HD, 32'h0000_0011);
      send(IN, ctl(1, 1, 4));
      send(PY, 32'd109);
      send(PY, 32'd110);
      send(PY, 32'd111);
      send(PY, 32'hFFFF_FFFB);
      out_ready = 1'b0;
      #1;
      chk("R6", {33'd0, in_ready}, 34'd0);
      chk("R5", {33'd0, out_valid}, 34'd1);
      held = out_data;
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         in_valid = 1'b1; in_type = PY; in_data = 32'd500;
         #1;
         chk("R6", {33'd0, in_ready}, 34'd0);
         chk("R10", {out_valid, 1'b0, out_data}, {1'b1, 1'b0, held});
         @(negedge clk);
      end
      in_valid = 1'b0;
      out_ready = 1'b1;
      idle(1);
      #1;
      chk("R7", {33'd0, in_ready}, 34'd1);
      @(negedge clk);
      expect_out(TL, 32'h0000_0077, "R7");
      expect_out(PY, 32'd300, "R7");
      send(TL, 32'h0000_0077);
      send(PY, 32'd300);
      idle(4);
      all_out("R4");
   endtask

   task automatic t_zero;
      expect_out(PY, 32'd42, "R8");
      send(IN, ctl(1, 1, 0));
      send(PY, 32'd42);
      idle(4);
      all_out("R8");
   endtask

   task automatic t_pending;
      out_ready = 1'b0;
      send(IN, ctl(3, 0, 2));
      in_type = PY; in_data = 32'd7; in_valid = 1'b1;
      #1;
      chk("R9", {33'd0, in_ready}, 34'd0);
      @(negedge clk);
      #1;
      chk("R9", {33'd0, in_ready}, 34'd0);
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 1'b1;
      expect_out(IN, ctl(3, 0, 2), "R9");
      expect_out(PY, 32'd7, "R9");
      send(PY, 32'd7);
      idle(4);
      all_out("R9");
   endtask

   task automatic t_full;
      out_ready = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         expect_out(PY, 32'(1000 + i), "R11");
         send(PY, 32'(1000 + i));
      end
      in_type = PY; in_data = 32'd99; in_valid = 1'b1;
      #1;
      chk("R11", {33'd0, in_ready}, 34'd0);
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 1'b1;
      idle(DEPTH + 2);
      all_out("R11");
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_pass;
      t_foreign;
      t_process;
      t_zero;
      t_pending;
      t_full;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule